// File: doc/BRIEF.md
# Chip-Select Bounds Address Decoder

This block takes a 40-bit physical address, usually the address captured when a memory error is logged, and reports which of four chip-select rows holds it. Each row owns a 32-bit bounds register written and read over a small register bus. A register packs a 16-bit start field and a 16-bit end field. Both fields are counted in 16 MiB units and are compared against the top sixteen address bits.

A lookup is requested by raising `lookupValid` for one cycle with the address on `errAddr`. One clock later `resultValid` pulses. At the same time the row index, a hit flag and an out-of-range flag appear, and they hold until the next lookup. A row whose start and end fields are equal is treated as empty. When rows overlap, the one with the lowest index is chosen.

Top module: `cs_bounds_decoder`

## Requirements
- R1: Row n's bounds register sits at byte offset n*8 (0x00, 0x08, 0x10, 0x18). A cycle with `regWrEn` high at such an offset loads `regWrData` into that row. A write to any offset whose low three bits are not zero changes no row.
- R2: A cycle with `regRdEn` high places the addressed row's register on `regRdData` at the next clock. An offset whose low three bits are not zero reads as zero. Without `regRdEn`, `regRdData` keeps its value.
- R3: Bits 31:16 of a bounds register are the start and bits 15:0 are the end. A row matches when start <= errAddr[39:24] <= end. The end is inclusive, so the whole final 16 MiB unit matches, up to an address whose low 24 bits are all ones.
- R4: A row whose start field equals its end field never matches. Lookups fall through to the next matching row, or to out-of-range.
- R5: When several rows match, `rowIdx` reports the lowest-indexed one.
- R6: When no row matches, the result is `rowHit`=0, `outOfRange`=1 and `rowIdx`=0. When a row matches, the result is `rowHit`=1 and `outOfRange`=0.
- R7: A lookup sampled at a clock edge produces `resultValid`=1 and its result at the following edge. `resultValid` is high for exactly one cycle per request.
- R8: In cycles without a lookup request, `rowIdx`, `rowHit` and `outOfRange` keep their last values.
- R9: Reset clears all bounds registers to zero (every row empty), clears `regRdData`, and clears every result output.
- R10: When a lookup and a bounds write happen in the same cycle, the lookup is decoded against the bounds held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 5 | Register byte offset |
| regWrData | input | 32 | Write data, start in 31:16, end in 15:0 |
| regRdData | output | 32 | Read data, valid the cycle after a read |
| lookupValid | input | 1 | Lookup request for `errAddr` |
| errAddr | input | 40 | Physical address to decode |
| resultValid | output | 1 | One-cycle pulse marking a fresh result |
| rowIdx | output | 2 | Index of the matching row |
| rowHit | output | 1 | Some row matched |
| outOfRange | output | 1 | No row matched |

## Verification
The hardest cases to reach are the boundary ones. One is an address at the very last byte of a row's final unit. Another is the first byte past it. A third is an address covered by two overlapping rows, while an empty row in between would match if emptiness were ignored. The bench programs an overlapping layout that includes an empty row, then aims lookups at both edges of each range. It also issues a bounds write in the same cycle as a lookup, to show that the old bounds are used. A pseudo-random run afterwards mixes in-range and out-of-range keys with reads. A behavioural model checks every cycle.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int NUM_ROWS = 4;
  localparam int IDX_W    = $clog2(NUM_ROWS);

  typedef struct packed {
    logic [NUM_ROWS-1:0] wrRow;
    logic                rdEn;
    logic                rdHit;
    logic [IDX_W-1:0]    rdRow;
    logic                lookupEn;
  } csStrobes_t;
endpackage

// File: rtl/csdec_ctrl.sv
module csdec_ctrl
  import csdec_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int ROW_STRIDE = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  lookupValid,
  output csStrobes_t            strobes,
  output logic                  resultValid
);
  localparam int STRIDE_LSB = $clog2(ROW_STRIDE);

  logic [STRIDE_LSB-1:0] offLow;
  logic [REG_ADDR_W-1:0] wordNum;
  logic [IDX_W-1:0]      rowSel;
  logic                  rowOk;

  assign offLow  = regAddr[STRIDE_LSB-1:0];
  assign wordNum = regAddr >> STRIDE_LSB;
  assign rowSel  = wordNum[IDX_W-1:0];
  assign rowOk   = (offLow == '0) && (wordNum < REG_ADDR_W'(NUM_ROWS));

  always_comb begin
    strobes = '0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      strobes.wrRow[r] = regWrEn && rowOk && (rowSel == IDX_W'(r));
    end
    strobes.rdEn     = regRdEn;
    strobes.rdHit    = rowOk;
    strobes.rdRow    = rowSel;
    strobes.lookupEn = lookupValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= lookupValid;
  end

  // R1: a bus write never lands in more than one row
  a_r1_single_row_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrRow));
endmodule

// File: rtl/csdec_datapath.sv
module csdec_datapath
  import csdec_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  csStrobes_t           strobes,
  input  logic                 resultValid,
  input  logic [2*FIELD_W-1:0] wrData,
  input  logic [FIELD_W-1:0]   keyVal,
  output logic [2*FIELD_W-1:0] rdData,
  output logic [IDX_W-1:0]     rowIdx,
  output logic                 rowHit,
  output logic                 outOfRange
);
  localparam int REG_W = 2 * FIELD_W;

  logic [REG_W-1:0]   bndQ   [NUM_ROWS];
  logic [FIELD_W-1:0] startF [NUM_ROWS];
  logic [FIELD_W-1:0] endF   [NUM_ROWS];
  logic [NUM_ROWS-1:0] rowMatch;

  for (genvar g = 0; g < NUM_ROWS; g++) begin : gRow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 bndQ[g] <= '0;
      else if (strobes.wrRow[g]) bndQ[g] <= wrData;
    end
    assign startF[g]   = bndQ[g][REG_W-1:FIELD_W];
    assign endF[g]     = bndQ[g][FIELD_W-1:0];
    assign rowMatch[g] = (startF[g] != endF[g]) &&
                         (keyVal >= startF[g]) && (keyVal <= endF[g]);
  end

  logic [IDX_W-1:0] foundIdx;
  logic             found;

  always_comb begin
    foundIdx = '0;
    found    = 1'b0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (rowMatch[i]) begin
        foundIdx = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowIdx     <= '0;
      rowHit     <= 1'b0;
      outOfRange <= 1'b0;
    end else if (strobes.lookupEn) begin
      rowIdx     <= foundIdx;
      rowHit     <= found;
      outOfRange <= !found;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobes.rdEn) rdData <= strobes.rdHit ? bndQ[strobes.rdRow] : '0;
  end

  logic [FIELD_W-1:0] selStart;
  logic [FIELD_W-1:0] selEnd;
  assign selStart = startF[rowIdx];
  assign selEnd   = endF[rowIdx];

  // R3: a reported hit lies inside the chosen row's inclusive bounds
  a_r3_hit_in_bounds: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && rowHit && $past(strobes.wrRow == '0) |->
      ($past(keyVal) >= selStart) && ($past(keyVal) <= selEnd));

  // R4: an empty row is never reported
  a_r4_no_empty_hit: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && rowHit && $past(strobes.wrRow == '0) |-> selStart != selEnd);

  // R6: each result is exactly one of hit or out-of-range
  a_r6_hit_xor_oor: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (rowHit != outOfRange));

  // R7: a valid result always follows a request one cycle earlier
  a_r7_valid_after_request: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(strobes.lookupEn));

  // R8: result outputs hold when no lookup was requested
  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.lookupEn) |-> $stable({rowIdx, rowHit, outOfRange}));
endmodule

// File: rtl/cs_bounds_decoder.sv
module cs_bounds_decoder
  import csdec_pkg::*;
#(
  parameter int PHYS_ADDR_W = 40,
  parameter int UNIT_SHIFT  = 24,
  parameter int REG_ADDR_W  = 5,
  parameter int ROW_STRIDE  = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  regWrEn,
  input  logic                                  regRdEn,
  input  logic [REG_ADDR_W-1:0]                 regAddr,
  input  logic [2*(PHYS_ADDR_W-UNIT_SHIFT)-1:0] regWrData,
  output logic [2*(PHYS_ADDR_W-UNIT_SHIFT)-1:0] regRdData,
  input  logic                                  lookupValid,
  input  logic [PHYS_ADDR_W-1:0]                errAddr,
  output logic                                  resultValid,
  output logic [IDX_W-1:0]                      rowIdx,
  output logic                                  rowHit,
  output logic                                  outOfRange
);
  localparam int FIELD_W = PHYS_ADDR_W - UNIT_SHIFT;

  csStrobes_t         strobes;
  logic [FIELD_W-1:0] keyVal;
  logic               unusedLowBits;

  assign keyVal        = errAddr[PHYS_ADDR_W-1:UNIT_SHIFT];
  assign unusedLowBits = ^errAddr[UNIT_SHIFT-1:0];

  csdec_ctrl #(
    .REG_ADDR_W (REG_ADDR_W),
    .ROW_STRIDE (ROW_STRIDE)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regAddr     (regAddr),
    .lookupValid (lookupValid),
    .strobes     (strobes),
    .resultValid (resultValid)
  );

  csdec_datapath #(
    .FIELD_W (FIELD_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .resultValid (resultValid),
    .wrData      (regWrData),
    .keyVal      (keyVal),
    .rdData      (regRdData),
    .rowIdx      (rowIdx),
    .rowHit      (rowHit),
    .outOfRange  (outOfRange)
  );
endmodule

// File: tb/tb_cs_bounds_decoder.sv
module tb_cs_bounds_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lookupValid = 1'b0;
  logic [39:0] errAddr = '0;
  logic        resultValid;
  logic [1:0]  rowIdx;
  logic        rowHit;
  logic        outOfRange;

  always #2.5 clk = ~clk;

  cs_bounds_decoder dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .lookupValid(lookupValid), .errAddr(errAddr), .resultValid(resultValid),
    .rowIdx(rowIdx), .rowHit(rowHit), .outOfRange(outOfRange)
  );

  // Behavioural reference model
  logic [31:0] mBnd [4] = '{default: 32'h0};
  logic        mValid = 1'b0;
  logic [1:0]  mIdx = '0;
  logic        mHit = 1'b0;
  logic        mOor = 1'b0;
  logic [31:0] mRd = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mBnd[i]) mBnd[i] = '0;
      mValid = 0; mIdx = 0; mHit = 0; mOor = 0; mRd = 0;
    end else begin
      if (lookupValid) begin
        int key;
        bit found;
        key = int'(errAddr[39:24]);
        found = 0;
        mIdx = 0;
        for (int i = 0; i < 4; i++) begin
          int s;
          int e;
          s = int'(mBnd[i][31:16]);
          e = int'(mBnd[i][15:0]);
          if (!found && s != e && key >= s && key <= e) begin
            found = 1;
            mIdx = 2'(i);
          end
        end
        mHit = found;
        mOor = !found;
        mValid = 1;
      end else begin
        mValid = 0;
      end
      if (regRdEn) mRd = (regAddr % 8 == 0) ? mBnd[regAddr / 8] : 32'h0;
      if (regWrEn && (regAddr % 8 == 0)) mBnd[regAddr / 8] = regWrData;
    end
  end

  int checks = 0;
  int errors = 0;
  string curTag = "R9";
  bit checking = 0;

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", curTag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      cmp("resultValid", 32'(resultValid), 32'(mValid));
      cmp("rowIdx", 32'(rowIdx), 32'(mIdx));
      cmp("rowHit", 32'(rowHit), 32'(mHit));
      cmp("outOfRange", 32'(outOfRange), 32'(mOor));
      cmp("regRdData", regRdData, mRd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(logic [4:0] a);
    regRdEn = 1; regAddr = a;
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic look(logic [15:0] key, logic [23:0] low);
    lookupValid = 1; errAddr = {key, low};
    @(negedge clk);
    lookupValid = 0;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    @(negedge clk);
    checking = 1;
    // R9: reset state
    curTag = "R9";
    idle(2);
    rstN = 1;
    idle(1);
    for (int i = 0; i < 4; i++) rd(5'(i * 8));
    look(16'h0000, 24'h0);
    idle(1);

    // R1 / R2: program rows and read back
    curTag = "R1";
    wr(5'h00, {16'h0000, 16'h0003});
    wr(5'h08, {16'h0004, 16'h0007});
    wr(5'h10, {16'h0010, 16'h0010});
    wr(5'h18, {16'h0006, 16'h0020});
    for (int i = 0; i < 4; i++) rd(5'(i * 8));
    wr(5'h04, 32'hDEAD_BEEF);
    wr(5'h09, 32'h1234_5678);
    for (int i = 0; i < 4; i++) rd(5'(i * 8));
    curTag = "R2";
    rd(5'h04);
    rd(5'h1F);
    idle(3);
    rd(5'h18);
    idle(2);

    // R3: inclusive bounds at both edges
    curTag = "R3";
    look(16'h0000, 24'h000000);
    look(16'h0003, 24'hFFFFFF);
    look(16'h0004, 24'h000000);
    look(16'h0020, 24'hFFFFFF);

    // R4: empty row 2 skipped, row 3 covers key 0x10
    curTag = "R4";
    look(16'h0010, 24'h000123);
    idle(1);

    // R5: overlap of rows 1 and 3
    curTag = "R5";
    look(16'h0006, 24'h000000);
    look(16'h0007, 24'hFFFFFF);

    // R6: nothing matches
    curTag = "R6";
    look(16'h0021, 24'h000000);
    look(16'hFFFF, 24'hFFFFFF);

    // R7: back-to-back and isolated requests
    curTag = "R7";
    look(16'h0001, 24'h0);
    look(16'h0005, 24'h0);
    idle(1);
    look(16'h0030, 24'h0);

    // R8: hold across idle cycles
    curTag = "R8";
    look(16'h0002, 24'h0);
    idle(4);

    // R10: write and lookup in the same cycle
    curTag = "R10";
    regWrEn = 1; regAddr = 5'h00; regWrData = {16'h0040, 16'h0050};
    lookupValid = 1; errAddr = {16'h0045, 24'h0};
    @(negedge clk);
    regWrEn = 0; lookupValid = 0;
    look(16'h0045, 24'h0);
    idle(1);

    // R3: pseudo-random sweep
    curTag = "R3";
    x = 32'h1357_9BDF;
    for (int n = 0; n < 400; n++) begin
      x = x * 32'd1103515245 + 32'd12345;
      lookupValid = x[3];
      errAddr = {16'((x >> 8) % 96), x[31:8]};
      regRdEn = x[5];
      regAddr = 5'(x[12:8]);
      @(negedge clk);
    end
    lookupValid = 0; regRdEn = 0;
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule